// File: doc/BRIEF.md
# Configurable Serial Transmitter

The block turns bytes written by a host into asynchronous serial frames on a single output line. A control register written over a byte-wide port chooses how many input clock cycles each serial bit lasts, which of eight frame layouts is sent, and the state of the request-to-send output and the transmit interrupt. One code of the divide field does not divide at all: it holds the whole transmitter in a master reset until a different control value is written.

Behind the control register sit a one-byte holding register and a shift register. The host writes a byte into the holding register. The byte moves into the shift register as soon as the line is free, or at the end of the frame in flight. The holding-register-empty flag tells the host when the next byte may be written, and can also raise an interrupt. Frames can follow each other with no idle time between them.

Top module: `cfg_serial_tx`

## Requirements
- R1: After rst_ni is released the control register holds the master-reset code (value 0x03), txd_o is high, tdre_o is 1, irq_o is 0 and rts_no is 0.
- R2: A control write with bits [1:0] = 11 stops any frame in flight. From the next cycle txd_o is high, tdre_o is 1 and irq_o is 0. Data writes made while this code is held are discarded, so no frame is sent once the code is left.
- R3: Control bits [1:0] = 00, 01 and 10 make every serial bit last exactly 1, 16 and 64 clock cycles.
- R4: A frame is a start bit of 0, then the data bits least significant first, then the parity bit when enabled, then the stop bits of 1. The line is high whenever no frame is being sent.
- R5: Control bits [4:2] = 000, 001, 010 and 011 give 7 data bits with, in that order, even parity and 2 stop bits, odd parity and 2 stop bits, even parity and 1 stop bit, and odd parity and 1 stop bit.
- R6: Control bits [4:2] = 100, 101, 110 and 111 give 8 data bits with, in that order, no parity and 2 stop bits, no parity and 1 stop bit, even parity and 1 stop bit, and odd parity and 1 stop bit. Control value 0x91 therefore sends 8 data bits, no parity and 2 stop bits at 16 cycles per bit.
- R7: rts_no (active low) is 1 only while control bits [6:5] = 10. It is 0 for 00, 01 and 11.
- R8: irq_o is 1 exactly when control bits [6:5] = 01, tdre_o is 1 and the master-reset code is not held.
- R9: A data write clears tdre_o in the next cycle. When the line is idle the byte moves to the shift register one cycle later, its start bit begins in that cycle, and tdre_o is set again. A byte written during a frame waits, with tdre_o at 0, and its start bit follows the last stop bit of the current frame with no idle cycle.
- R10: The frame layout and the bit length are fixed when a frame starts. A control write during the frame that does not select master reset leaves that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control value. Bit 7 belongs to the receive side and is not stored |
| data_we_i | input | 1 | Holding register write strobe |
| data_wdata_i | input | 8 | Byte to transmit |
| txd_o | output | 1 | Serial output, idles high |
| rts_no | output | 1 | Request to send, active low |
| tdre_o | output | 1 | Holding register empty |
| irq_o | output | 1 | Transmit interrupt |

## Verification
A wrong internal state shows up on txd_o or tdre_o within one bit time. A miscounted divide moves every later sample point, so the error grows across the frame and is caught at the exact boundary between the start bit and the first data bit. A wrong frame decode or parity shows up in the first frame captured for that code. A holding flag that never clears, or a byte kept through master reset, produces a frame where the line should stay idle, within a few cycles of leaving reset. The back-to-back case catches an idle gap or a lost byte at the join between two frames.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 12;
  localparam int DIV_MID = 16;
  localparam int DIV_MAX = 64;
  localparam int CNT_W   = $clog2(DIV_MAX);
  localparam int BITS_W  = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    DIV_ONE  = 2'b00,
    DIV_SIXT = 2'b01,
    DIV_SIXF = 2'b10,
    DIV_MRST = 2'b11
  } div_sel_e;

  typedef struct packed {
    logic len8;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    f.len8     = code[2];
    f.par_en   = !(code[2] && !code[1]);
    f.par_odd  = code[0];
    f.two_stop = (code[2:1] == 2'b00) || (code == 3'b100);
    return f;
  endfunction
endpackage

// File: rtl/cst_ctrl_reg.sv
module cst_ctrl_reg
  import cst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic       mrst_o,
  output div_sel_e   div_sel_o,
  output fmt_t       fmt_o,
  output logic       rts_no,
  output logic       tie_o
);
  logic [6:0] ctrl_q;
  logic       unused_rx_bit;

  assign unused_rx_bit = wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= 7'h03;
    else if (we_i) ctrl_q <= wdata_i[6:0];
  end

  assign div_sel_o = div_sel_e'(ctrl_q[1:0]);
  assign mrst_o    = (ctrl_q[1:0] == 2'b11);
  assign fmt_o     = decode_fmt(ctrl_q[4:2]);
  assign rts_no    = (ctrl_q[6:5] == 2'b10);
  assign tie_o     = (ctrl_q[6:5] == 2'b01);
endmodule

// File: rtl/cst_baud_gen.sv
module cst_baud_gen
  import cst_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mrst_i,
  input  logic     load_i,
  input  logic     en_i,
  input  div_sel_e div_sel_i,
  output logic     tick_o
);
  localparam logic [CNT_W-1:0] LimMid = CNT_W'(DIV_MID - 1);
  localparam logic [CNT_W-1:0] LimMax = CNT_W'(DIV_MAX - 1);

  div_sel_e         div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    unique case (div_q)
      DIV_SIXT: lim = LimMid;
      DIV_SIXF: lim = LimMax;
      default:  lim = '0;
    endcase
  end

  assign tick_o = en_i && (cnt_q == lim);

  // divide is latched at frame start (R10)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_ONE;
      cnt_q <= '0;
    end else if (mrst_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      div_q <= div_sel_i;
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cst_shifter.sv
module cst_shifter
  import cst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  fmt_t              fmt_i,
  input  logic              tick_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              txd_o,
  output logic              tdre_o
);
  logic [DATA_W-1:0]  hold_q;
  logic               full_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BITS_W-1:0]  left_q;
  logic               busy_q;
  logic [FRAME_W-1:0] frame_c;
  logic [BITS_W-1:0]  nbits_c;
  logic               pbit;
  logic               done;

  assign pbit = (fmt_i.len8 ? ^hold_q : ^hold_q[6:0]) ^ fmt_i.par_odd;

  always_comb begin
    if (!fmt_i.len8)       frame_c = {3'b111, pbit, hold_q[6:0], 1'b0};
    else if (fmt_i.par_en) frame_c = {2'b11, pbit, hold_q, 1'b0};
    else                   frame_c = {3'b111, hold_q, 1'b0};
    nbits_c = BITS_W'(1)
            + (fmt_i.len8 ? BITS_W'(8) : BITS_W'(7))
            + BITS_W'(fmt_i.par_en)
            + (fmt_i.two_stop ? BITS_W'(2) : BITS_W'(1));
  end

  assign done   = busy_q && tick_i && (left_q == BITS_W'(1));
  assign load_o = full_q && (!busy_q || done) && !mrst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (mrst_i) begin
      full_q <= 1'b0;
    end else if (data_we_i) begin
      hold_q <= data_i;
      full_q <= 1'b1;
    end else if (load_o) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (mrst_i) begin
      sh_q   <= '1;
      busy_q <= 1'b0;
    end else if (load_o) begin
      sh_q   <= frame_c;
      left_q <= nbits_c;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
      left_q <= left_q - 1'b1;
      if (left_q == BITS_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = (busy_q && !mrst_i) ? sh_q[0] : 1'b1;
  assign tdre_o = mrst_i || !full_q;
endmodule

// File: rtl/cfg_serial_tx.sv
module cfg_serial_tx
  import cst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  input  logic       data_we_i,
  input  logic [7:0] data_wdata_i,
  output logic       txd_o,
  output logic       rts_no,
  output logic       tdre_o,
  output logic       irq_o
);
  logic     mrst;
  logic     tie;
  div_sel_e div_sel;
  fmt_t     fmt;
  logic     tick;
  logic     load;
  logic     busy;
  logic     tdre;

  cst_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .mrst_o   (mrst),
    .div_sel_o(div_sel),
    .fmt_o    (fmt),
    .rts_no   (rts_no),
    .tie_o    (tie)
  );

  cst_baud_gen u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mrst_i   (mrst),
    .load_i   (load),
    .en_i     (busy),
    .div_sel_i(div_sel),
    .tick_o   (tick)
  );

  cst_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mrst_i   (mrst),
    .data_we_i(data_we_i),
    .data_i   (data_wdata_i),
    .fmt_i    (fmt),
    .tick_i   (tick),
    .load_o   (load),
    .busy_o   (busy),
    .txd_o    (txd_o),
    .tdre_o   (tdre)
  );

  assign tdre_o = tdre;
  assign irq_o  = tie && tdre && !mrst;
endmodule

// File: rtl/cst_checker.sv
module cst_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctrl_we_i,
  input logic [7:0] ctrl_wdata_i,
  input logic       data_we_i,
  input logic       mrst_i,
  input logic       txd_o,
  input logic       rts_no,
  input logic       tdre_o,
  input logic       irq_o
);
  assert_mrst_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && (ctrl_wdata_i[1:0] == 2'b11) |=> txd_o && tdre_o && !irq_o);

  assert_mrst_drops_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i && !ctrl_we_i |=> tdre_o && txd_o);

  assert_rts_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && (ctrl_wdata_i[6:5] != 2'b10) |=> !rts_no);

  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> tdre_o && !mrst_i);

  assert_tdre_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i && !mrst_i && !ctrl_we_i |=> !tdre_o);
endmodule

bind cfg_serial_tx cst_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_wdata_i(ctrl_wdata_i),
  .data_we_i   (data_we_i),
  .mrst_i      (mrst),
  .txd_o       (txd_o),
  .rts_no      (rts_no),
  .tdre_o      (tdre_o),
  .irq_o       (irq_o)
);

// File: tb/cfg_serial_tx_tb.sv
`timescale 1ns/1ps
module cfg_serial_tx_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic       data_we_i = 1'b0;
  logic [7:0] data_wdata_i = '0;
  logic       txd_o, rts_no, tdre_o, irq_o;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i;

  cfg_serial_tx u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .data_we_i(data_we_i), .data_wdata_i(data_wdata_i), .txd_o(txd_o), .rts_no(rts_no),
    .tdre_o(tdre_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void exp_frame(input logic [2:0] code, input logic [7:0] d,
                                    output logic [11:0] b, output int n);
    int  dl = code[2] ? 8 : 7;
    bit  pe = !(code == 3'b100 || code == 3'b101);
    int  st = (code == 3'b000 || code == 3'b001 || code == 3'b100) ? 2 : 1;
    logic p = code[0];
    b = '1;
    b[0] = 1'b0;
    n = 1;
    for (int i = 0; i < dl; i++) begin
      b[n] = d[i];
      p ^= d[i];
      n++;
    end
    if (pe) begin
      b[n] = p;
      n++;
    end
    n += st;
  endfunction

  function automatic int div_len(input logic [1:0] sel);
    return (sel == 2'b01) ? 16 : (sel == 2'b10) ? 64 : 1;
  endfunction

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk_i); ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i); ctrl_we_i = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk_i); data_we_i = 1'b1; data_wdata_i = v;
    @(negedge clk_i); data_we_i = 1'b0;
  endtask

  // call at the posedge where bit 0 begins; returns at the posedge after the last bit
  task automatic capture(input int div, input int n, output logic [11:0] got);
    got = '1;
    for (int i = 0; i < n; i++) begin
      repeat (div / 2) @(posedge clk_i);
      @(negedge clk_i);
      got[i] = txd_o;
      repeat (div - div / 2) @(posedge clk_i);
    end
  endtask

  task automatic t_reset();
    check("R1 txd", 32'(txd_o), 1);
    check("R1 tdre", 32'(tdre_o), 1);
    check("R1 irq", 32'(irq_o), 0);
    check("R1 rts", 32'(rts_no), 0);
    wr_data(8'h55);
    check("R1 reset code holds master reset", 32'(tdre_o), 1);
  endtask

  task automatic t_frame(input logic [7:0] ctrl, input logic [7:0] d, input string req);
    logic [11:0] got, exp;
    int n;
    int div = div_len(ctrl[1:0]);
    exp_frame(ctrl[4:2], d, exp, n);
    wr_ctrl(ctrl);
    wr_data(d);
    check("R9 tdre cleared by write", 32'(tdre_o), 0);
    @(posedge clk_i);
    capture(div, n, got);
    check(req, 32'(got), 32'(exp));
    @(negedge clk_i);
    check("R4 idle high after frame", 32'(txd_o), 1);
    check("R9 tdre set after move", 32'(tdre_o), 1);
  endtask

  task automatic t_bit_edge();
    wr_ctrl(8'h15);
    wr_data(8'h01);
    @(posedge clk_i);
    repeat (15) @(posedge clk_i);
    @(negedge clk_i);
    check("R3 start bit lasts 16 cycles", 32'(txd_o), 0);
    @(negedge clk_i);
    check("R3 data bit begins at cycle 16", 32'(txd_o), 1);
    repeat (150) @(posedge clk_i);
    @(negedge clk_i);
    check("R4 idle after 16x frame", 32'(txd_o), 1);
  endtask

  task automatic t_rts_irq();
    wr_ctrl(8'h15);
    check("R7 rts 00", 32'(rts_no), 0);
    check("R8 irq 00", 32'(irq_o), 0);
    wr_ctrl(8'h35);
    check("R7 rts 01", 32'(rts_no), 0);
    check("R8 irq 01", 32'(irq_o), 1);
    wr_ctrl(8'h55);
    check("R7 rts 10", 32'(rts_no), 1);
    check("R8 irq 10", 32'(irq_o), 0);
    wr_ctrl(8'h75);
    check("R7 rts 11", 32'(rts_no), 0);
    check("R8 irq 11", 32'(irq_o), 0);
    wr_ctrl(8'h35);
    wr_data(8'hC3);
    check("R8 irq low while full", 32'(irq_o), 0);
    @(negedge clk_i);
    check("R8 irq back after move", 32'(irq_o), 1);
    repeat (170) @(posedge clk_i);
    wr_ctrl(8'h23);
    check("R8 irq masked in master reset", 32'(irq_o), 0);
  endtask

  task automatic t_mrst();
    int bad = 0;
    wr_ctrl(8'h15);
    wr_data(8'h00);
    repeat (40) @(posedge clk_i);
    @(negedge clk_i);
    check("R2 frame running before abort", 32'(txd_o), 0);
    wr_ctrl(8'h03);
    check("R2 txd idle after abort", 32'(txd_o), 1);
    check("R2 tdre after abort", 32'(tdre_o), 1);
    wr_data(8'hAA);
    check("R2 data write ignored", 32'(tdre_o), 1);
    wr_ctrl(8'h15);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (txd_o !== 1'b1) bad++;
    end
    check("R2 no frame after leaving reset", 32'(bad), 0);
  endtask

  task automatic t_b2b();
    logic [11:0] ga, gb, ea, eb;
    int n;
    exp_frame(3'b101, 8'h96, ea, n);
    exp_frame(3'b101, 8'h3C, eb, n);
    wr_ctrl(8'h14);
    wr_data(8'h96);
    @(posedge clk_i);
    fork
      begin
        capture(1, n, ga);
        capture(1, n, gb);
      end
      begin
        @(negedge clk_i);
        check("R9 tdre set on move", 32'(tdre_o), 1);
        data_we_i = 1'b1; data_wdata_i = 8'h3C;
        @(negedge clk_i);
        data_we_i = 1'b0;
        check("R9 tdre low while waiting", 32'(tdre_o), 0);
        repeat (8) @(posedge clk_i);
        @(negedge clk_i);
        check("R9 tdre low in last bit", 32'(tdre_o), 0);
        @(negedge clk_i);
        check("R9 tdre set at frame join", 32'(tdre_o), 1);
      end
    join
    check("R9 first frame", 32'(ga), 32'(ea));
    check("R9 second frame with no gap", 32'(gb), 32'(eb));
  endtask

  task automatic t_latch();
    logic [11:0] got, exp;
    int n;
    exp_frame(3'b100, 8'h5A, exp, n);
    wr_ctrl(8'h11);
    wr_data(8'h5A);
    @(posedge clk_i);
    fork
      capture(16, n, got);
      begin
        repeat (20) @(posedge clk_i);
        wr_ctrl(8'h08);
      end
    join
    check("R10 frame unchanged by mid-frame write", 32'(got), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    for (int c = 0; c < 8; c++) begin
      t_frame({3'b000, 3'(c), 2'b00}, 8'hB5 ^ 8'(c * 37), c < 4 ? "R5 frame code" : "R6 frame code");
    end
    t_frame(8'h91, 8'hA7, "R6 R3 control 0x91 at 16x");
    t_frame(8'h0E, 8'h4D, "R3 R5 64x frame");
    t_frame(8'h1D, 8'h00, "R4 R6 all-zero data");
    t_bit_edge();
    t_rts_irq();
    t_mrst();
    t_b2b();
    t_latch();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule